// File: doc/BRIEF.md
# Indirect-Access Interrupt Status Register Unit

This block holds the host-visible interrupt state of a network controller. Software reaches it through two ports. A pointer port selects a register index. A data port then reads or writes the register that the pointer selects. There is no restriction on when an access may happen.

The central register is a status word. It holds three cause bits: receive, transmit and initialization-done. It also holds a read-only summary flag, a global interrupt enable and a stop control. The cause bits are write-one-to-clear, so software can read the word and write the same value back to acknowledge what it saw.

A second register holds per-cause mask bits, a receive look-ahead enable, and a special system cause that reaches the interrupt pin even when the global enable is off. Event pulses come from the rest of the controller and set the cause bits. An active-low interrupt line leaves the block.

Top module: `irq_csr_unit`

## Requirements
- R1: The pointer is 8 bits and resets to 0. A write with `sel_ptr`=1 loads `wdata[7:0]`. A read with `sel_ptr`=1 returns the pointer zero-extended. With `sel_ptr`=0, reads and writes reach the register that the pointer selects. An index other than 0 or 3 reads as zero, and writes to it change nothing.
- R2: Status word (index 0) layout:
  - bit 10 is the receive cause, bit 9 the transmit cause, bit 8 the init-done cause;
  - bit 7 is the read-only summary flag;
  - bit 6 is the global enable (read/write);
  - bit 2 is the stop control (read/write);
  - all other bits, including 31–16 and 15–11, read 0 whatever was written.
- R3: Writing 1 to status bits 10, 9 or 8 clears that cause. Writing 0 leaves it unchanged. Writing back a value just read clears every cause it showed.
- R4: When an event and a write-one-to-clear hit the same cause in the same cycle, the cause ends up set.
- R5: These clear all causes, including the system cause:
  - the asynchronous reset;
  - a `soft_rst` pulse, which also clears the enable and stop bits;
  - a status write with bit 2 = 1.
  A clear wins over an event in the same cycle.
- R6: Mask register (index 3) layout:
  - bits 10, 9, 8 mask the receive, transmit and init-done causes;
  - bit 5 is the receive look-ahead enable;
  - bit 14 is the system cause, which is write-one-to-clear;
  - all other bits read 0.
- R7: `ev_rx_last` always sets the receive cause. `ev_rx_first` sets it only while the look-ahead bit is 1.
- R8: Masks do not stop a cause from being recorded. The summary flag is 1 exactly when some cause is set with its mask bit 0, or when the system cause is set.
- R9: `irq_n` is low exactly when (summary AND global enable) or the system cause is set. It follows the register state in the same cycle.
- R10: `ev_sys` sets the system cause. While that cause is set, `irq_n` is low regardless of the enable and the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_ptr | input | 1 | 1 selects the pointer port, 0 the data port |
| wr_en | input | 1 | Write strobe for the selected port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected port (combinational) |
| ev_rx_last | input | 1 | Receive frame finished (last descriptor) |
| ev_rx_first | input | 1 | Receive frame started (first descriptor) |
| ev_tx_done | input | 1 | Transmit frame handed over |
| ev_init_done | input | 1 | Initialization finished |
| ev_sys | input | 1 | Special system cause event |
| soft_rst | input | 1 | Software reset pulse |
| irq_n | output | 1 | Active-low interrupt line |

## Verification
Every event pulse, pointer load and status or mask write takes effect at the clock edge that samples it. The new value is visible on `rdata`, and `irq_n` settles in the same cycle after that edge, because both are combinational from the registers. The bench drives on the falling edge and checks at the next falling edge, which lies after exactly one rising edge. Data-port reads are sampled 1 ns after `sel_ptr` is lowered, so no check depends on the order of processes at a clock edge.

The mask, cause and enable combinations are swept exhaustively against a summary and pin value computed in the bench.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int NCAUSE   = 4;
  localparam int C_INIT   = 0;
  localparam int C_TX     = 1;
  localparam int C_RX     = 2;
  localparam int C_SYS    = 3;
  // status word bit positions
  localparam int B_RX     = 10;
  localparam int B_TX     = 9;
  localparam int B_INIT   = 8;
  localparam int B_SUMM   = 7;
  localparam int B_IEN    = 6;
  localparam int B_STOP   = 2;
  // mask word bit positions
  localparam int B_SYS    = 14;
  localparam int B_LA     = 5;
endpackage

// File: rtl/csr_ptr_reg.sv
module csr_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PTR_W-1:0] d,
  output logic [PTR_W-1:0] q
);
  logic [PTR_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (ld) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= q_d;
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d)));  // R1
endmodule

// File: rtl/irq_cause_cell.sv
module irq_cause_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic w1c,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic upd;

  assign upd = set | w1c | clr;

  always_comb begin
    q_d = q;
    if (clr)      q_d = 1'b0;
    else if (set) q_d = 1'b1;
    else if (w1c) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> q);  // R4
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);  // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !set && !clr) |=> !q);  // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !w1c && !clr) |=> (q == $past(q)));  // R3
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] w1c,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    irq_cause_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set[i]),
      .w1c  (w1c[i]),
      .clr  (clr),
      .q    (q[i])
    );
  end
endmodule

// File: rtl/irq_out_logic.sv
module irq_out_logic
  import irq_csr_pkg::*;
(
  input  logic [NCAUSE-1:0] cause,
  input  logic [2:0]        mask,
  input  logic              ien,
  output logic              summary,
  output logic              irq_n
);
  logic [2:0] live;

  always_comb begin
    live    = cause[2:0] & ~mask;
    summary = (|live) | cause[C_SYS];
    irq_n   = ~((summary & ien) | cause[C_SYS]);
  end
endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
  import irq_csr_pkg::*;
#(
  parameter int PTR_W    = 8,
  parameter int DATA_W   = 32,
  parameter int STAT_IDX = 0,
  parameter int MASK_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_ptr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ev_rx_last,
  input  logic              ev_rx_first,
  input  logic              ev_tx_done,
  input  logic              ev_init_done,
  input  logic              ev_sys,
  input  logic              soft_rst,
  output logic              irq_n
);
  // reset: asserted asynchronously, released through two flops
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [PTR_W-1:0] ptr_q;
  logic             ptr_ld, stat_hit, mask_hit, stat_wr, mask_wr;

  assign ptr_ld   = wr_en & sel_ptr;
  assign stat_hit = (ptr_q == PTR_W'(STAT_IDX));
  assign mask_hit = (ptr_q == PTR_W'(MASK_IDX));
  assign stat_wr  = wr_en & ~sel_ptr & stat_hit;
  assign mask_wr  = wr_en & ~sel_ptr & mask_hit;

  csr_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk  (clk),
    .rst_n(rs_n),
    .ld   (ptr_ld),
    .d    (wdata[PTR_W-1:0]),
    .q    (ptr_q)
  );

  // control bits: enable, stop, masks, look-ahead
  logic       ien_q, stop_q, la_q, ien_d, stop_d, la_d;
  logic [2:0] msk_q, msk_d;
  logic       ctl_en, clr_all;

  assign clr_all = soft_rst | (stat_wr & wdata[B_STOP]);
  assign ctl_en  = soft_rst | stat_wr | mask_wr;

  always_comb begin
    ien_d  = ien_q;
    stop_d = stop_q;
    msk_d  = msk_q;
    la_d   = la_q;
    if (soft_rst) begin
      ien_d  = 1'b0;
      stop_d = 1'b0;
    end else if (stat_wr) begin
      ien_d  = wdata[B_IEN];
      stop_d = wdata[B_STOP];
    end
    if (mask_wr) begin
      msk_d = {wdata[B_RX], wdata[B_TX], wdata[B_INIT]};
      la_d  = wdata[B_LA];
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      ien_q  <= 1'b0;
      stop_q <= 1'b0;
      msk_q  <= '0;
      la_q   <= 1'b0;
    end else if (ctl_en) begin
      ien_q  <= ien_d;
      stop_q <= stop_d;
      msk_q  <= msk_d;
      la_q   <= la_d;
    end
  end

  // cause bits
  logic [NCAUSE-1:0] c_set, c_w1c, cause_q;

  always_comb begin
    c_set         = '0;
    c_set[C_RX]   = ev_rx_last | (ev_rx_first & la_q);
    c_set[C_TX]   = ev_tx_done;
    c_set[C_INIT] = ev_init_done;
    c_set[C_SYS]  = ev_sys;
    c_w1c         = '0;
    c_w1c[C_RX]   = stat_wr & wdata[B_RX];
    c_w1c[C_TX]   = stat_wr & wdata[B_TX];
    c_w1c[C_INIT] = stat_wr & wdata[B_INIT];
    c_w1c[C_SYS]  = mask_wr & wdata[B_SYS];
  end

  irq_cause_bank #(.N(NCAUSE)) u_bank (
    .clk  (clk),
    .rst_n(rs_n),
    .set  (c_set),
    .w1c  (c_w1c),
    .clr  (clr_all),
    .q    (cause_q)
  );

  logic summary;
  irq_out_logic u_out (
    .cause  (cause_q),
    .mask   (msk_q),
    .ien    (ien_q),
    .summary(summary),
    .irq_n  (irq_n)
  );

  // read path
  logic [DATA_W-1:0] stat_word, mask_word;
  always_comb begin
    stat_word         = '0;
    stat_word[B_RX]   = cause_q[C_RX];
    stat_word[B_TX]   = cause_q[C_TX];
    stat_word[B_INIT] = cause_q[C_INIT];
    stat_word[B_SUMM] = summary;
    stat_word[B_IEN]  = ien_q;
    stat_word[B_STOP] = stop_q;
    mask_word         = '0;
    mask_word[B_SYS]  = cause_q[C_SYS];
    mask_word[B_RX]   = msk_q[2];
    mask_word[B_TX]   = msk_q[1];
    mask_word[B_INIT] = msk_q[0];
    mask_word[B_LA]   = la_q;
    if (sel_ptr)       rdata = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
    else if (stat_hit) rdata = stat_word;
    else if (mask_hit) rdata = mask_word;
    else               rdata = '0;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rs_n)
    !irq_n |-> (|cause_q));  // R9
  AST_SYS_FORCES_IRQ: assert property (@(posedge clk) disable iff (!rs_n)
    cause_q[C_SYS] |-> !irq_n);  // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rs_n)
    (!sel_ptr && stat_hit) |-> (rdata[DATA_W-1:B_RX+1] == '0));  // R2
  AST_LA_GATE: assert property (@(posedge clk) disable iff (!rs_n)
    (!la_q && !ev_rx_last && ev_rx_first && !cause_q[C_RX]) |=> !cause_q[C_RX]);  // R7
endmodule

// File: tb/test_irq_csr_unit.sv
module test_irq_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n, sel_ptr, wr_en;
  logic [31:0] wdata, rdata;
  logic        ev_rx_last, ev_rx_first, ev_tx_done, ev_init_done, ev_sys, soft_rst;
  logic        irq_n;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_csr_unit i_irq_csr_unit (
    .clk(clk), .rst_n(rst_n), .sel_ptr(sel_ptr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ev_rx_last(ev_rx_last),
    .ev_rx_first(ev_rx_first), .ev_tx_done(ev_tx_done),
    .ev_init_done(ev_init_done), .ev_sys(ev_sys),
    .soft_rst(soft_rst), .irq_n(irq_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sp, logic [31:0] d);
    sel_ptr = sp; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; sel_ptr = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [31:0] v);
    wr(1'b1, {24'b0, idx});
    sel_ptr = 1'b0; #1; v = rdata;
  endtask

  task automatic ev(logic rl, logic rf, logic tx, logic in, logic sy);
    ev_rx_last = rl; ev_rx_first = rf; ev_tx_done = tx; ev_init_done = in; ev_sys = sy;
    @(negedge clk);
    ev_rx_last = 0; ev_rx_first = 0; ev_tx_done = 0; ev_init_done = 0; ev_sys = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; sel_ptr = 0; wr_en = 0; wdata = 0; soft_rst = 0;
    ev_rx_last = 0; ev_rx_first = 0; ev_tx_done = 0; ev_init_done = 0; ev_sys = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // reset state
    sel_ptr = 1; #1; check("R1 ptr reset", rdata, 0); sel_ptr = 0;
    rd(0, v); check("R2 status reset", v, 0);
    check("R9 irq_n reset", {31'b0, irq_n}, 1);

    // pointer readback, unimplemented index
    wr(1, 32'hFFFF_FFA5); sel_ptr = 1; #1; check("R1 ptr readback", rdata, 32'hA5); sel_ptr = 0;
    wr(0, 32'hFFFF_FFFF); #1; check("R1 unimpl read zero", rdata, 0);
    rd(3, v); check("R1 unimpl write ignored (mask)", v, 0);
    rd(0, v); check("R1 unimpl write ignored (status)", v, 0);

    // reserved/obsolete bits read zero
    rd(0, v); wr(0, 32'hFFFF_F800); #1; check("R2 reserved read zero", rdata, 0);
    wr(0, 32'h0000_0044); #1; check("R2 ien and stop r/w", rdata, 32'h44);
    wr(0, 32'h0); #1; check("R2 ien and stop cleared", rdata, 0);

    // exhaustive sweep: masks x causes x enable
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 8; c++)
        for (int e = 0; e < 2; e++) begin
          logic [2:0] mm, cc;
          logic sm;
          mm = 3'(m); cc = 3'(c);
          rd(0, v); wr(0, 32'h700);
          rd(3, v); wr(0, {21'b0, mm, 8'b0});
          ev(cc[2], 1'b0, cc[1], cc[0], 1'b0);
          rd(0, v); wr(0, {25'b0, 1'(e), 6'b0});
          #1; v = rdata;
          sm = |(cc & ~mm);
          check("R8 sweep status", v, {21'b0, cc, sm, 1'(e), 6'b0});
          check("R9 sweep irq_n", {31'b0, irq_n}, {31'b0, ~(sm & 1'(e))});
        end

    // W1C: writing zero keeps, write-back clears
    rd(3, v); wr(0, 0);
    rd(0, v); wr(0, 32'h700);
    ev(1, 0, 1, 1, 0);
    rd(0, v); wr(0, 32'h0); #1; check("R3 write zero keeps", rdata, 32'h780);
    v = rdata; wr(0, v); #1; check("R3 write-back clears", rdata, 0);
    ev(1, 0, 1, 0, 0);
    wr(0, 32'h200); #1; check("R3 clear only tx", rdata, 32'h480);

    // set wins over W1C
    ev_tx_done = 1; wr(0, 32'h200); ev_tx_done = 0; #1;
    check("R4 set beats w1c", rdata, 32'h680);

    // stop clears, beats event
    ev_init_done = 1; wr(0, 32'h4); ev_init_done = 0; #1;
    check("R5 stop clears and beats event", rdata, 32'h4);
    wr(0, 0);
    ev(1, 0, 0, 0, 0); wr(0, 32'h40);
    soft_rst = 1; @(negedge clk); soft_rst = 0; #1;
    check("R5 soft reset clears", rdata, 0);

    // look-ahead gating
    ev(0, 1, 0, 0, 0); #1; check("R7 first ignored la=0", rdata, 0);
    rd(3, v); wr(0, 32'h20); #1; check("R6 la readback", rdata, 32'h20);
    ev(0, 1, 0, 0, 0);
    rd(0, v); check("R7 first sets la=1", v, 32'h480);
    wr(0, 32'h400); rd(3, v); wr(0, 32'h700); #1;
    check("R6 mask readback", rdata, 32'h700);

    // system cause bypasses enable and masks
    ev(1, 0, 1, 1, 0); rd(0, v); check("R8 masked causes recorded", v, 32'h700);
    check("R9 masked no irq", {31'b0, irq_n}, 1);
    ev(0, 0, 0, 0, 1); #1;
    check("R10 sys irq with ien=0", {31'b0, irq_n}, 0);
    check("R8 summary from sys", rdata, 32'h780);
    rd(3, v); check("R6 sys bit readback", v, 32'h4700);
    wr(0, 32'h4700); #1; check("R6 sys w1c", rdata, 32'h700);
    check("R10 irq released", {31'b0, irq_n}, 1);

    // async reset
    ev(0, 0, 0, 0, 1); rst_n = 0; #1;
    check("R5 async reset irq", {31'b0, irq_n}, 1);
    @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
    rd(3, v); check("R5 async reset mask", v, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule